// File: doc/BRIEF.md
# Receive sampling tap tuning engine

This engine searches for the best receive sampling tap of a high-speed eMMC link. A controller pulses `start_i`. The engine then walks the tap value upward from zero through a safe sub-range of the field width. It programs each tap through a self-clearing update handshake and runs a tuning-block test against it.

Taps that pass the test form runs of consecutive passing taps. The engine keeps the longest run it has seen. After the last tap it programs the tap at the centre of that run and raises `done_o`. The tuning command and the pattern comparison are outside this block and are reached through the test request/response pair.

Programming a tap always issues two update requests with the same value, and each one waits for its completion. An update that is not completed within a bounded number of cycles counts as a failure.

Top module: `tap_tuner`

## Requirements
- R1: Taps are visited in ascending order from 0 to NUM_TAPS-1 (0..39 by default). A tap whose programming succeeds gets exactly one test request. `test_req_o` and `tune_upd_o` are never high together.
- R2: Programming a tap raises `tune_upd_o` with `tune_val_o` held steady until `tune_ack_i` is seen. After one low cycle, a second request with the same value follows and waits for its own acknowledge.
- R3: If `tune_upd_o` stays high for UPD_TIMEOUT cycles without `tune_ack_i`, the request is dropped. The tap counts as failing, and no second request and no test are issued for it.
- R4: A passing tap extends the current run by one and a failing tap clears it. A run replaces the stored best run only when it is strictly longer, so of two equal runs the earlier one is kept.
- R5: After the sweep, the engine programs the tap equal to the best run's last tap minus floor(best length / 2). It uses the double request of R2, then pulses `done_o` with `error_o` low and leaves that tap on `tune_val_o`.
- R6: If no tap passed, `done_o` and `error_o` pulse together and no further update request is issued.
- R7: A start with `is_mmc_i` low or `cmd_hs200_i` low is rejected. `done_o` and `error_o` are high in the cycle after the start is sampled, and no update or test request is made.
- R8: If programming the chosen tap times out, `done_o` pulses with `error_o` high.
- R9: `start_i` has no effect while `busy_o` is high. `done_o` is a one-cycle pulse, `error_o` is high only together with `done_o`, and `busy_o` is low whenever `done_o` is high.
- R10: After reset, `busy_o`, `done_o`, `error_o`, `tune_upd_o` and `test_req_o` are low and `tune_val_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tuning run (sampled while idle) |
| is_mmc_i | input | 1 | Attached card is eMMC |
| cmd_hs200_i | input | 1 | Requested tuning command is the HS200 one |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Run failed, valid with `done_o` |
| tune_val_o | output | TAP_W | Tap value being programmed |
| tune_upd_o | output | 1 | Update request, held until acknowledged or timed out |
| tune_ack_i | input | 1 | Update completed |
| test_req_o | output | 1 | Tuning-block test request, held until answered |
| test_done_i | input | 1 | Test finished |
| test_pass_i | input | 1 | Test result, valid with `test_done_i` |

## Verification
A rejected start is registered once, so its `done_o`/`error_o` pair is due exactly one cycle after the sampling edge. The bench checks it at the next falling edge. Sweep results finish after a response-dependent number of cycles. For these, the bench waits for the `done_o` pulse and then checks the held tap, the error flag, and the counts of update rises and tests that its responders recorded. Its one-cycle pulse width is checked at the following falling edge. All sampling and driving happen on falling edges, away from the edge where the registers change.

// File: rtl/tap_tuner_pkg.sv
package tap_tuner_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_TEST,
    ST_PICK,
    ST_FINAL
  } tuner_st_e;

  typedef enum logic [1:0] {
    AP_IDLE,
    AP_REQ,
    AP_GAP
  } apply_st_e;
endpackage

// File: rtl/tap_apply.sv
module tap_apply
  import tap_tuner_pkg::*;
#(
  parameter int UPD_TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic ack_i,
  output logic upd_o,
  output logic fin_o,
  output logic ok_o
);
  localparam int CNT_W = $clog2(UPD_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UPD_TIMEOUT - 1);

  apply_st_e        st_q;
  logic             second_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= AP_IDLE;
      second_q <= 1'b0;
      cnt_q    <= '0;
      fin_o    <= 1'b0;
      ok_o     <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      unique case (st_q)
        AP_IDLE: if (go_i) begin
          st_q     <= AP_REQ;
          second_q <= 1'b0;
          cnt_q    <= '0;
        end
        AP_REQ: begin
          // ack wins over timeout in the last allowed cycle
          if (ack_i) begin
            if (second_q) begin
              st_q  <= AP_IDLE;
              fin_o <= 1'b1;
              ok_o  <= 1'b1;
            end else begin
              st_q     <= AP_GAP;
              second_q <= 1'b1;
            end
          end else if (cnt_q == CNT_LAST) begin
            st_q  <= AP_IDLE;
            fin_o <= 1'b1;
            ok_o  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        AP_GAP: begin
          st_q  <= AP_REQ;
          cnt_q <= '0;
        end
        default: st_q <= AP_IDLE;
      endcase
    end
  end

  assign upd_o = (st_q == AP_REQ);
endmodule

// File: rtl/tap_streak.sv
module tap_streak #(
  parameter int TAP_W = 6,
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [LEN_W-1:0] best_len_o,
  output logic [TAP_W-1:0] pick_o
);
  logic [LEN_W-1:0] cur_q, best_q;
  logic [TAP_W-1:0] end_q;
  logic [LEN_W-1:0] cur_inc;

  assign cur_inc = cur_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (clear_i) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (step_i) begin
      if (pass_i) begin
        cur_q <= cur_inc;
        // strict compare keeps the earliest of equal runs
        if (cur_inc > best_q) begin
          best_q <= cur_inc;
          end_q  <= tap_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  assign best_len_o = best_q;
  assign pick_o     = end_q - TAP_W'(best_q >> 1);
endmodule

// File: rtl/tap_tuner.sv
module tap_tuner
  import tap_tuner_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int NUM_TAPS    = 40,
  parameter int UPD_TIMEOUT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_mmc_i,
  input  logic             cmd_hs200_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic [TAP_W-1:0] tune_val_o,
  output logic             tune_upd_o,
  input  logic             tune_ack_i,
  output logic             test_req_o,
  input  logic             test_done_i,
  input  logic             test_pass_i
);
  localparam int LEN_W = $clog2(NUM_TAPS + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  tuner_st_e        st_q;
  logic [TAP_W-1:0] tap_q;
  logic             go_q, done_q, err_q, treq_q;
  logic             ap_fin, ap_ok;
  logic             clr, step, pass;
  logic [LEN_W-1:0] best_len;
  logic [TAP_W-1:0] pick;

  assign clr  = (st_q == ST_IDLE) && start_i && is_mmc_i && cmd_hs200_i;
  assign step = ((st_q == ST_APPLY) && ap_fin && !ap_ok) ||
                ((st_q == ST_TEST) && test_done_i);
  assign pass = (st_q == ST_TEST) && test_pass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tap_q  <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      treq_q <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (!(is_mmc_i && cmd_hs200_i)) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st_q  <= ST_APPLY;
            tap_q <= '0;
            go_q  <= 1'b1;
          end
        end
        ST_APPLY: if (ap_fin) begin
          if (ap_ok) begin
            st_q   <= ST_TEST;
            treq_q <= 1'b1;
          end else if (tap_q == LAST_TAP) begin
            st_q <= ST_PICK;
          end else begin
            tap_q <= tap_q + 1'b1;
            go_q  <= 1'b1;
          end
        end
        ST_TEST: if (test_done_i) begin
          treq_q <= 1'b0;
          if (tap_q == LAST_TAP) begin
            st_q <= ST_PICK;
          end else begin
            st_q  <= ST_APPLY;
            tap_q <= tap_q + 1'b1;
            go_q  <= 1'b1;
          end
        end
        ST_PICK: begin
          if (best_len == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st_q  <= ST_FINAL;
            tap_q <= pick;
            go_q  <= 1'b1;
          end
        end
        ST_FINAL: if (ap_fin) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          err_q  <= !ap_ok;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  tap_apply #(
    .UPD_TIMEOUT(UPD_TIMEOUT)
  ) u_apply (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go_q),
    .ack_i (tune_ack_i),
    .upd_o (tune_upd_o),
    .fin_o (ap_fin),
    .ok_o  (ap_ok)
  );

  tap_streak #(
    .TAP_W(TAP_W),
    .LEN_W(LEN_W)
  ) u_streak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr),
    .step_i    (step),
    .pass_i    (pass),
    .tap_i     (tap_q),
    .best_len_o(best_len),
    .pick_o    (pick)
  );

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;
  assign tune_val_o = tap_q;
  assign test_req_o = treq_q;
endmodule

// File: rtl/tap_tuner_chk.sv
module tap_tuner_chk #(
  parameter int TAP_W       = 6,
  parameter int UPD_TIMEOUT = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             error_o,
  input logic [TAP_W-1:0] tune_val_o,
  input logic             tune_upd_o,
  input logic             tune_ack_i,
  input logic             test_req_o
);
  localparam int HI_W = $clog2(UPD_TIMEOUT + 1);
  logic [HI_W-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else if (tune_upd_o && !tune_ack_i) hi_cnt_q <= hi_cnt_q + 1'b1;
    else hi_cnt_q <= '0;
  end

  a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(test_req_o && tune_upd_o));

  a_r2_val_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_upd_o |-> $stable(tune_val_o));

  a_r3_req_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_upd_o |-> (hi_cnt_q < HI_W'(UPD_TIMEOUT)));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  a_r9_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind tap_tuner tap_tuner_chk #(
  .TAP_W(TAP_W),
  .UPD_TIMEOUT(UPD_TIMEOUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .error_o   (error_o),
  .tune_val_o(tune_val_o),
  .tune_upd_o(tune_upd_o),
  .tune_ack_i(tune_ack_i),
  .test_req_o(test_req_o)
);

// File: tb/tap_tuner_bench.sv
module tap_tuner_bench;
  localparam int N   = 40;
  localparam int TO  = 8;
  localparam int LAT = 2;
  localparam int TW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start, is_mmc, hs200;
  logic busy, done, error, upd, ack, treq, tdone, tpass;
  logic [TW-1:0] val;

  tap_tuner #(.TAP_W(TW), .NUM_TAPS(N), .UPD_TIMEOUT(TO)) u_tap_tuner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_mmc_i(is_mmc),
    .cmd_hs200_i(hs200), .busy_o(busy), .done_o(done), .error_o(error),
    .tune_val_o(val), .tune_upd_o(upd), .tune_ack_i(ack),
    .test_req_o(treq), .test_done_i(tdone), .test_pass_i(tpass)
  );

  int total = 0, bad = 0;
  int rise_cnt = 0, test_cnt = 0, done_cnt = 0, s_exp = 0, wcnt = 0;
  logic [63:0] mask_q = '0, blk_q = '0;
  logic kill_q = 1'b0, prev_upd = 1'b0;
  logic [TW-1:0] rvals [0:127];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // responders: update acknowledge and tuning test
  initial begin
    ack = 1'b0; tdone = 1'b0; tpass = 1'b0;
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (upd && !prev_upd) begin
        if (rise_cnt < 128) rvals[rise_cnt] = val;
        rise_cnt++;
      end
      prev_upd = upd;
      if (upd && !ack && ((rise_cnt <= s_exp) ? !blk_q[val] : !kill_q)) begin
        if (wcnt >= LAT) ack = 1'b1;
        else wcnt++;
      end else begin
        ack = 1'b0;
        wcnt = 0;
      end
      if (treq && !tdone) begin
        tdone = 1'b1;
        tpass = mask_q[val];
        test_cnt++;
      end else begin
        tdone = 1'b0;
        tpass = 1'b0;
      end
    end
  end

  task automatic run(input logic [63:0] mask, input logic [63:0] blk,
                     input bit kill, input bit again);
    int s = 0, cur = 0, best = 0, endt = 0, tests = 0, fin = 0;
    int exp_rises, n = 0, k = 0, mism = 0;
    bit exp_err;
    for (int i = 0; i < N; i++) begin
      if (blk[i]) s += 1;
      else begin s += 2; tests++; end
      if (mask[i] && !blk[i]) begin
        cur++;
        if (cur > best) begin best = cur; endt = i; end
      end else cur = 0;
    end
    fin = endt - best / 2;
    exp_err = (best == 0) || kill;
    exp_rises = (best == 0) ? s : (kill ? s + 1 : s + 2);
    mask_q = mask; blk_q = blk; kill_q = kill; s_exp = s;
    rise_cnt = 0; test_cnt = 0; done_cnt = 0;
    is_mmc = 1'b1; hs200 = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (again) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) begin
      chk(1'b0, "R9 run never finished", n, 0);
      return;
    end
    chk(error == exp_err, "R6 R8 error flag", int'(error), int'(exp_err));
    if (best > 0) chk(val == TW'(fin), "R4 R5 chosen tap", int'(val), fin);
    chk(rise_cnt == exp_rises, "R2 R3 update request count", rise_cnt, exp_rises);
    chk(test_cnt == tests, "R1 R3 test count", test_cnt, tests);
    for (int i = 0; i < N; i++) begin
      if (rvals[k] != TW'(i)) mism++;
      k++;
      if (!blk[i]) begin
        if (rvals[k] != TW'(i)) mism++;
        k++;
      end
    end
    if (best > 0) begin
      if (rvals[k] != TW'(fin)) mism++;
      if (!kill && rvals[k+1] != TW'(fin)) mism++;
    end
    chk(mism == 0, "R1 R2 R5 request order", mism, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9 single done (start while busy ignored)", done_cnt, 1);
  endtask

  task automatic reject(input logic m, input logic h);
    rise_cnt = 0; test_cnt = 0;
    is_mmc = m; hs200 = h;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done && error, "R7 reject done+error", int'({done, error}), 3);
    @(negedge clk);
    chk(!done, "R7 R9 reject pulse", int'(done), 0);
    repeat (5) @(negedge clk);
    chk(rise_cnt == 0 && test_cnt == 0 && !busy, "R7 no requests", rise_cnt + test_cnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R9 watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [63:0] m, b;
    start = 1'b0; is_mmc = 1'b1; hs200 = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !upd && !treq && val == '0,
        "R10 reset state", int'({busy, done, error, upd, treq}), 0);

    reject(1'b0, 1'b1);
    reject(1'b1, 1'b0);

    run(64'hFF_FFFF_FFFF, '0, 1'b0, 1'b0);           // R5 all pass -> 19
    run('0, '0, 1'b0, 1'b0);                          // R6 none pass
    run(64'h1F0_00F8, '0, 1'b0, 1'b0);                // R4 tie keeps earlier -> 5
    run(64'h1F_FFF0_0001, '0, 1'b0, 1'b0);            // R4 later longer run
    run(64'hFF_FFFF_FFFF, 64'h400, 1'b0, 1'b0);       // R3 timeout at tap 10 -> 25
    run(64'hFF_FFFF_FFFF, '0, 1'b1, 1'b0);            // R8 final apply times out
    run(64'h00_0FF0_0FF0, 64'h8_0000_0001, 1'b0, 1'b1); // R9 start while busy
    for (int t = 0; t < N; t++) run(64'd1 << t, '0, 1'b0, 1'b0); // R5 single pass sweep
    lf = 32'hACE1_1234;
    for (int r = 0; r < 6; r++) begin
      m = '0; b = '0;
      for (int i = 0; i < N; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        m[i] = (lf[1:0] != 2'b00);
        b[i] = (lf[6:2] == 5'd3);
      end
      run(m, b, 1'b0, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule